// File: doc/BRIEF.md
# Serial EEPROM Sequential Byte Fetcher

This block fetches a run of bytes from a small serial EEPROM over a four-wire SPI-style link. The four wires are an active-low select, a serial clock, a line carrying data to the device and a line carrying data from the device. A typical use is reading a stored station address at boot. The user side asserts a one-cycle start with a byte address and a byte count. The block then returns each fetched byte with a one-cycle strobe and pulses a completion flag after the last one. A second start mode reads the device's status byte.

The block builds every serial clock half-period from a fixed number of system clock cycles. Each byte is fetched in a self-contained transaction: select low, the read command, the address, eight data clocks, then select high for one settle half-period. The address then steps by one and wraps at the top of the 8-bit space. The first transaction after reset is preceded once by two wake clock pulses with select held high. Read data is passed through a two-stage synchronizer. It is sampled at the end of each clock-low half and assembled most significant bit first.

Top module: `spi_rom_fetch`

## Requirements
- R1: During and after reset, with no transaction running, the select pin is high, the serial clock and the data-out pin are low, and neither the byte strobe nor the completion flag is asserted.
- R2: The first transaction after reset is preceded by the clock pattern high, low, high, low with select held high, each level lasting one half-period. Later transactions do not repeat it.
- R3: A data read shifts out command 0000_0011 and then the 8-bit address, both most significant bit first. The data-out pin changes only together with a falling (or absent) clock edge and holds steady through each clock-high half. It is low during the data clocks.
- R4: Every serial clock level, and every select-high settle interval, lasts exactly HALF_CYC system clock cycles.
- R5: Read data is sampled at the end of each clock-low half after the command and address, assembled MSB first. The byte is presented on byte_data_o with a one-cycle byte_valid_o in the last cycle of the transaction's final clock-high half.
- R6: A read of N bytes runs N separate transactions. Select returns high for one half-period after each byte, and the address increases by one between bytes, wrapping from 0xFF to 0x00.
- R7: A start with status_req_i high sends command 0000_0101, gives eight data clocks, returns exactly one byte and ignores the address and count inputs.
- R8: done_o pulses for one cycle, one half-period after the last byte's strobe, when the block returns to idle.
- R9: A start that arrives while a transaction or settle interval is still running has no effect. This includes the final cycle of the last settle interval.
- R10: A data-read start with a count of zero produces done_o in the next cycle, no pin activity and no byte strobe, and does not use up the wake sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a fetch |
| status_req_i | input | 1 | With start_i: read the status byte instead of memory |
| addr_i | input | 8 | First byte address |
| count_i | input | CNT_W | Number of bytes to fetch |
| byte_valid_o | output | 1 | One-cycle strobe marking a fetched byte |
| byte_data_o | output | 8 | Fetched byte, valid with byte_valid_o |
| done_o | output | 1 | One-cycle pulse when the request has finished |
| rom_cs_n_o | output | 1 | Device select, active low |
| rom_sck_o | output | 1 | Serial clock to the device |
| rom_mosi_o | output | 1 | Serial data to the device |
| rom_miso_i | input | 1 | Serial data from the device |

## Verification
The coincidence that matters is a new start request landing in the same cycle the block finishes. The last settle interval is ending and done_o is about to rise. The bench raises start_i one cycle before the final settle cycle ends and holds it for two edges. The bench model expects the first edge to be ignored, because the block is still in its settle interval. It expects the second edge, in the cycle done_o is visible, to begin a fresh transaction. Any pin, strobe or flag that departs from the model's cycle-by-cycle stream shows which case the design got wrong.

// File: rtl/spi_rom_fetch_pkg.sv
package spi_rom_fetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_XFER,
    ST_GAP
  } seq_state_e;

  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam int         CMD_BITS   = 8;
  localparam int         ADDR_BITS  = 8;
  localparam int         DATA_BITS  = 8;
  localparam int         MAX_SLOTS  = CMD_BITS + ADDR_BITS + DATA_BITS;
  localparam int         IDX_W      = $clog2(2 * MAX_SLOTS);
  localparam int         SLOT_W     = IDX_W - 1;
  localparam logic [IDX_W-1:0] WAKE_LAST = IDX_W'(3);

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0};

  // number of bits sent towards the device before data clocks begin
  function automatic logic [SLOT_W-1:0] tx_bits(input logic is_status);
    return is_status ? SLOT_W'(CMD_BITS) : SLOT_W'(CMD_BITS + ADDR_BITS);
  endfunction

  // index of the final phase (clock-high) of one transaction
  function automatic logic [IDX_W-1:0] last_phase(input logic is_status);
    return IDX_W'(2 * (32'(tx_bits(is_status)) + DATA_BITS) - 1);
  endfunction

  // bit presented on the data-out pin during a given slot
  function automatic logic frame_bit(input logic is_status,
                                     input logic [7:0] addr,
                                     input logic [SLOT_W-1:0] slot);
    logic [15:0] word;
    word = {(is_status ? OP_STATUS : OP_READ), addr};
    if (slot < tx_bits(is_status)) return word[4'd15 - slot[3:0]];
    return 1'b0;
  endfunction

  function automatic logic [7:0] next_addr(input logic [7:0] a);
    return a + 8'd1;
  endfunction

endpackage

// File: rtl/spi_rom_fetch_timer.sv
module spi_rom_fetch_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/spi_rom_fetch_sync.sv
module spi_rom_fetch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= 1'b0;
        else        pipe_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= 1'b0;
        else        pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_rom_fetch_seq.sv
module spi_rom_fetch_seq
  import spi_rom_fetch_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             status_req_i,
  input  logic [7:0]       addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             tick_i,
  input  logic             miso_i,
  output pin_set_t         pins_o,
  output logic             busy_o,
  output logic             waking_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             woke_q;
  logic [7:0]       addr_q;
  logic [CNT_W-1:0] left_q;
  logic             status_q;
  logic [7:0]       shreg_q;
  logic [7:0]       data_q;
  logic             valid_q;
  logic             done_q;

  logic [SLOT_W-1:0] slot;
  logic              low_half;
  logic              sample_now;
  logic              frame_end;

  assign slot       = idx_q[IDX_W-1:1];
  assign low_half   = !idx_q[0];
  assign sample_now = low_half && (slot >= tx_bits(status_q));
  assign frame_end  = (idx_q == last_phase(status_q));

  assign busy_o       = (state_q != ST_IDLE);
  assign waking_o     = (state_q == ST_WAKE);
  assign byte_valid_o = valid_q;
  assign byte_data_o  = data_q;
  assign done_o       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      woke_q   <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
      status_q <= 1'b0;
      shreg_q  <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q   <= addr_i;
            status_q <= status_req_i;
            idx_q    <= '0;
            left_q   <= status_req_i ? CNT_W'(1) : count_i;
            if (!status_req_i && (count_i == '0)) done_q  <= 1'b1;
            else                                  state_q <= woke_q ? ST_XFER : ST_WAKE;
          end
        end
        ST_WAKE: begin
          if (tick_i) begin
            if (idx_q == WAKE_LAST) begin
              state_q <= ST_XFER;
              idx_q   <= '0;
              woke_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        ST_XFER: begin
          if (tick_i) begin
            if (sample_now) shreg_q <= {shreg_q[6:0], miso_i};
            if (frame_end) begin
              state_q <= ST_GAP;
              valid_q <= 1'b1;
              data_q  <= shreg_q;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        ST_GAP: begin
          if (tick_i) begin
            if (left_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              left_q  <= left_q - CNT_W'(1);
              addr_q  <= next_addr(addr_q);
              state_q <= ST_XFER;
              idx_q   <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pins_o = PINS_IDLE;
    unique case (state_q)
      ST_WAKE: pins_o.sck = !idx_q[0];
      ST_XFER: begin
        pins_o.cs_n = 1'b0;
        pins_o.sck  = idx_q[0];
        pins_o.mosi = frame_bit(status_q, addr_q, slot);
      end
      default: pins_o = PINS_IDLE;
    endcase
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));

  // R5
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (state_q == ST_GAP));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q != ST_IDLE) |=> $stable(status_q));

endmodule

// File: rtl/spi_rom_fetch.sv
module spi_rom_fetch
  import spi_rom_fetch_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             status_req_i,
  input  logic [7:0]       addr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  output logic             done_o,
  output logic             rom_cs_n_o,
  output logic             rom_sck_o,
  output logic             rom_mosi_o,
  input  logic             rom_miso_i
);
  // HALF_CYC must be at least SYNC_STAGES + 2 so synchronized data is ready
  logic     phase_tick;
  logic     seq_busy;
  logic     seq_waking;
  logic     miso_s;
  pin_set_t pins_next;
  pin_set_t pins_q;

  spi_rom_fetch_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (seq_busy),
    .tick_o (phase_tick)
  );

  spi_rom_fetch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rom_miso_i),
    .q_o   (miso_s)
  );

  spi_rom_fetch_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .status_req_i (status_req_i),
    .addr_i       (addr_i),
    .count_i      (count_i),
    .tick_i       (phase_tick),
    .miso_i       (miso_s),
    .pins_o       (pins_next),
    .busy_o       (seq_busy),
    .waking_o     (seq_waking),
    .byte_valid_o (byte_valid_o),
    .byte_data_o  (byte_data_o),
    .done_o       (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_IDLE;
    else        pins_q <= pins_next;
  end

  assign rom_cs_n_o = pins_q.cs_n;
  assign rom_sck_o  = pins_q.sck;
  assign rom_mosi_o = pins_q.mosi;

  // R2
  wake_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs_n_o && rom_sck_o) |-> $past(seq_waking));

  // R3
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_sck_o) |-> $stable(rom_mosi_o));

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_cs_n_o) |-> $past(byte_valid_o));

endmodule

// File: tb/spi_rom_fetch_bench.sv
module spi_rom_fetch_bench;
  localparam int HALF = 4;
  localparam logic [7:0] STATUS_VAL = 8'hC6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       start = 1'b0, status_req = 1'b0;
  logic [7:0] addr = 8'h00, count = 8'h00;
  logic       byte_valid, done;
  logic [7:0] byte_data;
  logic       rom_cs_n, rom_sck, rom_mosi;
  logic       rom_miso = 1'b0;

  spi_rom_fetch #(.HALF_CYC(HALF), .SYNC_STAGES(2), .CNT_W(8)) u_spi_rom_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(start), .status_req_i(status_req),
    .addr_i(addr), .count_i(count), .byte_valid_o(byte_valid),
    .byte_data_o(byte_data), .done_o(done), .rom_cs_n_o(rom_cs_n),
    .rom_sck_o(rom_sck), .rom_mosi_o(rom_mosi), .rom_miso_i(rom_miso)
  );

  typedef struct {
    logic cs_n; logic sck; logic mosi; logic valid; logic done; logic [7:0] data;
  } exp_t;

  exp_t  exp_q[$];
  int    checks = 0, fails = 0, valids_seen = 0, cyc = 0;
  string scn = "R1";
  bit    woke_m = 1'b0;

  function automatic logic [7:0] rom_val(input logic [7:0] a);
    logic [7:0] t;
    t = a * 8'd37 + 8'd92;
    return t ^ {2'b00, a[7:2]};
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e.cs_n = 1'b1; e.sck = 1'b0; e.mosi = 1'b0; e.valid = 1'b0; e.done = 1'b0; e.data = 8'h00;
    return e;
  endfunction

  task automatic check_eq(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic push_phase(logic cs_n, logic sck, logic mosi);
    exp_t e;
    e = idle_e();
    e.cs_n = cs_n; e.sck = sck; e.mosi = mosi;
    repeat (HALF) exp_q.push_back(e);
  endtask

  // expected stream from the cycle after the accepting edge onwards
  task automatic build(bit st, logic [7:0] a, int cnt);
    exp_t e;
    logic [15:0] word;
    int ntx, nbytes;
    e = idle_e();
    if (!st && cnt == 0) begin
      e.done = 1'b1;           // R10: done right after the start edge
      exp_q.push_back(e);
      return;
    end
    exp_q.push_back(e);
    if (!woke_m) begin         // R2: two wake pulses, select high
      push_phase(1'b1, 1'b1, 1'b0);
      push_phase(1'b1, 1'b0, 1'b0);
      push_phase(1'b1, 1'b1, 1'b0);
      push_phase(1'b1, 1'b0, 1'b0);
      woke_m = 1'b1;
    end
    nbytes = st ? 1 : cnt;     // R7: count ignored for status
    ntx    = st ? 8 : 16;
    for (int b = 0; b < nbytes; b++) begin
      word = {(st ? 8'h05 : 8'h03), a};
      for (int s = 0; s < ntx + 8; s++) begin
        logic bitv;
        bitv = (s < ntx) ? word[15 - s] : 1'b0;
        push_phase(1'b0, 1'b0, bitv);
        push_phase(1'b0, 1'b1, bitv);
      end
      exp_q[exp_q.size()-1].valid = 1'b1;
      exp_q[exp_q.size()-1].data  = st ? STATUS_VAL : rom_val(a);
      push_phase(1'b1, 1'b0, 1'b0);
      if (b == nbytes - 1) exp_q[exp_q.size()-1].done = 1'b1;
      a = a + 8'd1;            // R6: wraps at 0xFF
    end
  endtask

  task automatic issue(bit st, logic [7:0] a, int cnt);
    @(posedge clk); #2;
    start = 1'b1; status_req = st; addr = a; count = 8'(cnt);
    valids_seen = 0;
    @(posedge clk); #2;
    start = 1'b0;
    build(st, a, cnt);
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #2; end while (exp_q.size() != 0);
    repeat (3) @(posedge clk);
  endtask

  // behavioural device: command and address in on rising clock, data out on falling clock
  logic [7:0] dev_op = 8'h00, dev_addr = 8'h00, dev_byte;
  int dev_rx = 0, dev_out = 0;

  always @(negedge rom_cs_n) begin
    dev_rx = 0; dev_out = 0; dev_op = 8'h00;
  end

  always @(posedge rom_sck) begin
    if (!rom_cs_n) begin
      if (dev_rx < 8) begin
        dev_op = {dev_op[6:0], rom_mosi}; dev_rx++;
      end else if (dev_op == 8'h03 && dev_rx < 16) begin
        dev_addr = {dev_addr[6:0], rom_mosi}; dev_rx++;
      end
    end
  end

  always @(negedge rom_sck) begin
    if (!rom_cs_n && dev_out < 8 &&
        ((dev_op == 8'h03 && dev_rx == 16) || (dev_op == 8'h05 && dev_rx == 8))) begin
      dev_byte = (dev_op == 8'h05) ? STATUS_VAL : rom_val(dev_addr);
      rom_miso = dev_byte[7 - dev_out];
      dev_out++;
    end
  end

  // cycle-by-cycle comparison against the model stream
  always @(negedge clk) begin : cmp
    exp_t e;
    if (rst_n) begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_e();
      checks++;
      if (rom_cs_n !== e.cs_n || rom_sck !== e.sck || rom_mosi !== e.mosi ||
          byte_valid !== e.valid || done !== e.done ||
          (e.valid && byte_data !== e.data)) begin
        fails++;
        $display("FAIL %s cycle %0d: got cs_n=%b sck=%b mosi=%b valid=%b done=%b data=%h expected cs_n=%b sck=%b mosi=%b valid=%b done=%b data=%h",
                 scn, cyc, rom_cs_n, rom_sck, rom_mosi, byte_valid, done, byte_data,
                 e.cs_n, e.sck, e.mosi, e.valid, e.done, e.data);
      end
      if (byte_valid) valids_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: got no completion by cycle %0d expected finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    // R1 reset state
    check_eq("R1", rom_cs_n, 1, "cs_n in reset");
    check_eq("R1", rom_sck, 0, "sck in reset");
    check_eq("R1", rom_mosi, 0, "mosi in reset");
    check_eq("R1", byte_valid, 0, "valid in reset");
    check_eq("R1", done, 0, "done in reset");
    rst_n = 1'b1;
    repeat (10) @(posedge clk);

    scn = "R10";
    issue(1'b0, 8'h44, 0);
    wait_idle();
    check_eq("R10", valids_seen, 0, "strobes for zero count");

    scn = "R2 R3 R4 R5";
    issue(1'b0, 8'h5A, 1);
    wait_idle();
    check_eq("R5", valids_seen, 1, "strobes for one byte");

    scn = "R6 R8";
    issue(1'b0, 8'hFE, 4);
    wait_idle();
    check_eq("R6", valids_seen, 4, "strobes across address wrap");

    scn = "R7";
    issue(1'b1, 8'h12, 9);
    wait_idle();
    check_eq("R7", valids_seen, 1, "strobes for status read");

    scn = "R9";
    issue(1'b0, 8'h10, 2);
    repeat (37) @(posedge clk); #2;
    start = 1'b1; status_req = 1'b1; addr = 8'h80; count = 8'd5;
    @(posedge clk); #2; start = 1'b0;
    repeat (150) @(posedge clk); #2;
    start = 1'b1; status_req = 1'b0; addr = 8'h81; count = 8'd0;
    @(posedge clk); #2; start = 1'b0;
    wait_idle();
    check_eq("R9", valids_seen, 2, "strobes with starts while busy");

    // R9 start held across the final settle cycle: first edge ignored, second taken
    scn = "R9 R8";
    issue(1'b0, 8'h20, 1);
    do begin @(posedge clk); #2; end while (exp_q.size() != 2);
    start = 1'b1; status_req = 1'b0; addr = 8'h33; count = 8'd1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    start = 1'b0;
    build(1'b0, 8'h33, 1);
    wait_idle();
    check_eq("R9", valids_seen, 2, "strobes for back-to-back start");

    scn = "R5 R6";
    issue(1'b0, 8'h00, 3);
    wait_idle();
    check_eq("R5", valids_seen, 3, "strobes from address zero");
    issue(1'b0, 8'hA5, 2);
    wait_idle();
    check_eq("R5", valids_seen, 2, "strobes from 0xA5");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule